// File: doc/BRIEF.md
# Transceiver Transmit-Enable Sequencer

This controller brings up a group of serial transceiver lanes that feed an upstream link, and it coordinates a downstream converter synchronization subsystem. After the reference clock is reported stable it waits a fixed time for the PLLs to lock. It then drives one enable bit per lane. A lane whose bit is low has its transmitter inhibited.

When converter synchronization is built in, lane 0 stays dark while the receive link is down, so the uplink does not see this node before the converter chain is ready. Once the receive link is up and the first downstream repeater reports up, the sequencer runs a bring-up sequence and then lights lane 0. It holds the converter framing core in reset until that point.

Every timestamp-load event restarts a realignment: one reference-to-timestamp alignment request, then one resynchronization request per converter. Each request is a single-cycle pulse. A shared done/error response pair answers it, and the sequencer waits for that response before it issues the next request.

Top module: `txen_seq`

## Requirements
- R1: During and after reset, all lane enables are 0, the framing-core reset is 1, no request is pulsed and both error flags are 0.
- R2: After `clk_stable_i` is sampled high, lane enables stay 0 for exactly LOCK_CYC = (CLK_HZ/1e6)*LOCK_US cycles.
- R3: Without synchronization support (HAS_SYNC=0), all lane enables go to 1 at the end of the lock wait and stay there. The framing-core reset stays 1 and no request is ever issued.
- R4: With synchronization support, from the end of the lock wait until bring-up completes, the enable mask is all ones except bit 0.
- R5: The framing-core reset stays 1 until the repeater is seen rising while the receive link is up. It falls one cycle before the converter-init request.
- R6: On that rising edge the order is fixed: framing-core reset release, converter-init request, automatic reference-alignment request, then all enables set. Each request waits for done or error, and an error does not stop the sequence.
- R7: The previous-repeater flag is cleared whenever the receive link comes back up, so a repeater that is already up starts bring-up again. A repeater that stays up does not start it again.
- R8: A timestamp-load event while idle in the running state pulses the timestamp-alignment request, then pulses the resync request with `resync_idx_o` = 0, 1, …, DACS-1 in order.
- R9: An error answer to the timestamp-alignment request sets `align_err_o`, and all resync requests still follow.
- R10: An error answer to a resync request sets `resync_err_o`, and no further resync requests are issued. Both error flags clear when the next timestamp-load sequence starts.
- R11: Requests are single-cycle pulses, at most one at a time. Done or error while no request is outstanding has no effect. The next request follows the cycle after a completion.
- R12: With synchronization support, if the receive link is low in a cycle, then in the next cycle lane 0 is disabled and the framing-core reset is 1. Any outstanding step is abandoned.
- R13: Timestamp-load is ignored outside the running state. When a repeater rising edge and a timestamp-load arrive in the same cycle, bring-up runs and the timestamp-load is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_stable_i | input | 1 | Reference clock reported stable |
| link_rx_up_i | input | 1 | Upstream receive link up |
| rep0_up_i | input | 1 | First downstream repeater up |
| ts_load_i | input | 1 | Timestamp-load event (one cycle) |
| step_done_i | input | 1 | Outstanding step finished |
| step_err_i | input | 1 | Outstanding step finished with an error |
| tx_en_o | output | LANES | Per-lane transmit enable |
| jesd_rst_o | output | 1 | Converter framing-core reset |
| dac_init_req_o | output | 1 | Converter-init request pulse |
| sysref_auto_req_o | output | 1 | Automatic reference-alignment request pulse |
| sysref_ts_req_o | output | 1 | Reference-to-timestamp alignment request pulse |
| resync_req_o | output | 1 | Converter resync request pulse |
| resync_idx_o | output | max(1,clog2(DACS)) | Converter index of the resync request |
| align_err_o | output | 1 | Timestamp alignment reported an error |
| resync_err_o | output | 1 | A resync step failed and the rest were aborted |

## Verification
A wrong state register shows up at the ports in the cycle after the transition that corrupted it. A sequencer stuck in the wrong mode lights lane 0 early or late and holds or releases the framing-core reset at the wrong time. A lost edge flag or step index either skips or repeats a request pulse, or moves it by a cycle. A lost outstanding-step bit does the same. The bench therefore compares every output against a behavioural model on every clock, so such faults are caught at the first diverging cycle.

// File: rtl/txen_pkg.sv
package txen_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOCKWAIT, ST_HIDDEN, ST_BRINGUP, ST_RUN, ST_RESYNC
  } seq_state_e;

  typedef enum logic [1:0] {
    BP_RELEASE, BP_INIT, BP_AUTO
  } bring_ph_e;

  typedef enum logic {
    RP_TSALIGN, RP_DAC
  } resync_ph_e;

  typedef enum logic [1:0] {
    MASK_NONE, MASK_HIDE, MASK_ALL
  } mask_mode_e;

  typedef enum logic [2:0] {
    STEP_NONE, STEP_INIT, STEP_AUTO, STEP_TSALIGN, STEP_RESYNC
  } step_kind_e;

endpackage

// File: rtl/txen_lock_timer.sv
module txen_lock_timer #(
  parameter int LOCK_CYC = 75000,
  localparam int CNT_W = $clog2(LOCK_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic expire_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = run_i ? cnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expire_o = run_i && (cnt_q == CNT_W'(LOCK_CYC - 1));

endmodule

// File: rtl/txen_step_hs.sv
module txen_step_hs (
  input  logic clk,
  input  logic rst_n,
  input  logic go_i,
  input  logic done_i,
  input  logic err_i,
  output logic req_o,
  output logic ok_o,
  output logic fail_o
);

  logic pend_q, pend_d;

  assign req_o  = go_i && !pend_q;
  assign fail_o = go_i && pend_q && err_i;
  assign ok_o   = go_i && pend_q && done_i && !err_i;

  always_comb begin
    if (!go_i)                       pend_d = 1'b0;
    else if (req_o)                  pend_d = 1'b1;
    else if (pend_q && (done_i || err_i)) pend_d = 1'b0;
    else                             pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  // R11: a request never lasts more than one cycle
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |=> !req_o);

  // R11: a completion is only ever reported for an issued step
  a_r11_no_orphan_done: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> !(ok_o || fail_o));

endmodule

// File: rtl/txen_mask_gen.sv
module txen_mask_gen
  import txen_pkg::*;
#(
  parameter int LANES = 4
) (
  input  mask_mode_e       mode_i,
  output logic [LANES-1:0] mask_o
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g == 0) begin : g_hidden_lane
      assign mask_o[g] = (mode_i == MASK_ALL);
    end else begin : g_plain_lane
      assign mask_o[g] = (mode_i == MASK_ALL) || (mode_i == MASK_HIDE);
    end
  end

endmodule

// File: rtl/txen_seq_fsm.sv
module txen_seq_fsm
  import txen_pkg::*;
#(
  parameter bit HAS_SYNC = 1'b1,
  parameter int DACS     = 3,
  localparam int DIDX_W  = (DACS > 1) ? $clog2(DACS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_stable_i,
  input  logic              link_up_i,
  input  logic              rep_up_i,
  input  logic              ts_load_i,
  input  logic              lock_done_i,
  input  logic              ok_i,
  input  logic              fail_i,
  output logic              lock_run_o,
  output logic              go_o,
  output step_kind_e        kind_o,
  output logic [DIDX_W-1:0] idx_o,
  output mask_mode_e        mask_mode_o,
  output logic              jesd_rst_o,
  output logic              align_err_o,
  output logic              resync_err_o
);

  localparam logic [DIDX_W-1:0] LAST_IDX = DIDX_W'(DACS - 1);

  seq_state_e        st_q, st_d;
  bring_ph_e         bph_q, bph_d;
  resync_ph_e        rph_q, rph_d;
  logic [DIDX_W-1:0] idx_q, idx_d;
  logic              unhid_q, unhid_d;
  logic              jon_q, jon_d;
  logic              prev_q, prev_d;
  logic              aerr_q, aerr_d;
  logic              rerr_q, rerr_d;
  logic              active;
  logic              rise;

  assign active = (st_q == ST_RUN) || (st_q == ST_BRINGUP) || (st_q == ST_RESYNC);
  assign rise   = (st_q == ST_RUN) && rep_up_i && !prev_q;

  always_comb begin
    st_d    = st_q;
    bph_d   = bph_q;
    rph_d   = rph_q;
    idx_d   = idx_q;
    unhid_d = unhid_q;
    jon_d   = jon_q;
    aerr_d  = aerr_q;
    rerr_d  = rerr_q;
    prev_d  = active ? rep_up_i : 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (clk_stable_i) st_d = ST_LOCKWAIT;
      end
      ST_LOCKWAIT: begin
        if (lock_done_i) begin
          if (HAS_SYNC) begin
            st_d = ST_HIDDEN;
          end else begin
            st_d    = ST_RUN;
            unhid_d = 1'b1;
          end
        end
      end
      ST_HIDDEN: begin
        unhid_d = 1'b0;
        jon_d   = 1'b0;
        if (link_up_i) st_d = ST_RUN;
      end
      ST_RUN: begin
        if (HAS_SYNC) begin
          if (!link_up_i) begin
            st_d = ST_HIDDEN; jon_d = 1'b0; unhid_d = 1'b0;
          end else if (rise) begin
            st_d  = ST_BRINGUP;
            bph_d = BP_RELEASE;
            jon_d = 1'b1;
          end else if (ts_load_i) begin
            st_d   = ST_RESYNC;
            rph_d  = RP_TSALIGN;
            idx_d  = '0;
            aerr_d = 1'b0;
            rerr_d = 1'b0;
          end
        end
      end
      ST_BRINGUP: begin
        if (!link_up_i) begin
          st_d = ST_HIDDEN; jon_d = 1'b0; unhid_d = 1'b0;
        end else begin
          unique case (bph_q)
            BP_RELEASE: bph_d = BP_INIT;
            BP_INIT:    if (ok_i || fail_i) bph_d = BP_AUTO;
            BP_AUTO: begin
              if (ok_i || fail_i) begin
                unhid_d = 1'b1;
                st_d    = ST_RUN;
              end
            end
            default:    bph_d = BP_RELEASE;
          endcase
        end
      end
      ST_RESYNC: begin
        if (!link_up_i) begin
          st_d = ST_HIDDEN; jon_d = 1'b0; unhid_d = 1'b0;
        end else if (rph_q == RP_TSALIGN) begin
          if (fail_i) begin
            aerr_d = 1'b1;
            rph_d  = RP_DAC;
          end else if (ok_i) begin
            rph_d  = RP_DAC;
          end
        end else begin
          if (fail_i) begin
            rerr_d = 1'b1;
            st_d   = ST_RUN;
          end else if (ok_i) begin
            if (idx_q == LAST_IDX) st_d = ST_RUN;
            else                   idx_d = idx_q + 1'b1;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      bph_q   <= BP_RELEASE;
      rph_q   <= RP_TSALIGN;
      idx_q   <= '0;
      unhid_q <= 1'b0;
      jon_q   <= 1'b0;
      prev_q  <= 1'b0;
      aerr_q  <= 1'b0;
      rerr_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      bph_q   <= bph_d;
      rph_q   <= rph_d;
      idx_q   <= idx_d;
      unhid_q <= unhid_d;
      jon_q   <= jon_d;
      prev_q  <= prev_d;
      aerr_q  <= aerr_d;
      rerr_q  <= rerr_d;
    end
  end

  always_comb begin
    go_o   = 1'b0;
    kind_o = STEP_NONE;
    if (link_up_i) begin
      if (st_q == ST_BRINGUP && bph_q != BP_RELEASE) begin
        go_o   = 1'b1;
        kind_o = (bph_q == BP_INIT) ? STEP_INIT : STEP_AUTO;
      end else if (st_q == ST_RESYNC) begin
        go_o   = 1'b1;
        kind_o = (rph_q == RP_TSALIGN) ? STEP_TSALIGN : STEP_RESYNC;
      end
    end
  end

  always_comb begin
    if (st_q == ST_IDLE || st_q == ST_LOCKWAIT) mask_mode_o = MASK_NONE;
    else if (unhid_q)                           mask_mode_o = MASK_ALL;
    else                                        mask_mode_o = MASK_HIDE;
  end

  assign lock_run_o   = (st_q == ST_LOCKWAIT);
  assign idx_o        = idx_q;
  assign jesd_rst_o   = !jon_q;
  assign align_err_o  = aerr_q;
  assign resync_err_o = rerr_q;

  // R10: a failed resync step ends the sequence with the flag raised
  a_r10_abort_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RESYNC && rph_q == RP_DAC && link_up_i && fail_i)
      |=> (st_q == ST_RUN && rerr_q));

  // R7: bring-up starts only from a low-to-high repeater transition
  a_r7_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && prev_q) |=> (st_q != ST_BRINGUP));

endmodule

// File: rtl/txen_seq.sv
module txen_seq
  import txen_pkg::*;
#(
  parameter int  LANES    = 4,
  parameter int  DACS     = 3,
  parameter int  CLK_HZ   = 50_000_000,
  parameter int  LOCK_US  = 1500,
  parameter bit  HAS_SYNC = 1'b1,
  localparam int DIDX_W   = (DACS > 1) ? $clog2(DACS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_stable_i,
  input  logic              link_rx_up_i,
  input  logic              rep0_up_i,
  input  logic              ts_load_i,
  input  logic              step_done_i,
  input  logic              step_err_i,
  output logic [LANES-1:0]  tx_en_o,
  output logic              jesd_rst_o,
  output logic              dac_init_req_o,
  output logic              sysref_auto_req_o,
  output logic              sysref_ts_req_o,
  output logic              resync_req_o,
  output logic [DIDX_W-1:0] resync_idx_o,
  output logic              align_err_o,
  output logic              resync_err_o
);

  localparam int LOCK_CYC = (CLK_HZ / 1_000_000) * LOCK_US;

  logic       lock_run, lock_done;
  logic       go, req, ok, fail;
  step_kind_e kind;
  mask_mode_e mode;

  txen_lock_timer #(.LOCK_CYC(LOCK_CYC)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (lock_run),
    .expire_o (lock_done)
  );

  txen_step_hs u_hs (
    .clk    (clk),
    .rst_n  (rst_n),
    .go_i   (go),
    .done_i (step_done_i),
    .err_i  (step_err_i),
    .req_o  (req),
    .ok_o   (ok),
    .fail_o (fail)
  );

  txen_seq_fsm #(.HAS_SYNC(HAS_SYNC), .DACS(DACS)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .clk_stable_i (clk_stable_i),
    .link_up_i    (link_rx_up_i),
    .rep_up_i     (rep0_up_i),
    .ts_load_i    (ts_load_i),
    .lock_done_i  (lock_done),
    .ok_i         (ok),
    .fail_i       (fail),
    .lock_run_o   (lock_run),
    .go_o         (go),
    .kind_o       (kind),
    .idx_o        (resync_idx_o),
    .mask_mode_o  (mode),
    .jesd_rst_o   (jesd_rst_o),
    .align_err_o  (align_err_o),
    .resync_err_o (resync_err_o)
  );

  txen_mask_gen #(.LANES(LANES)) u_mask (
    .mode_i (mode),
    .mask_o (tx_en_o)
  );

  assign dac_init_req_o    = req && (kind == STEP_INIT);
  assign sysref_auto_req_o = req && (kind == STEP_AUTO);
  assign sysref_ts_req_o   = req && (kind == STEP_TSALIGN);
  assign resync_req_o      = req && (kind == STEP_RESYNC);

  // R11: never two requests in one cycle
  a_r11_one_request: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dac_init_req_o, sysref_auto_req_o, sysref_ts_req_o, resync_req_o}));

  // R2: all lanes dark while waiting for lock
  a_r2_dark_in_lock: assert property (@(posedge clk) disable iff (!rst_n)
    lock_run |-> (tx_en_o == '0));

  // R5: the framing core is out of reset whenever converter init is requested
  a_r5_release_first: assert property (@(posedge clk) disable iff (!rst_n)
    dac_init_req_o |-> !jesd_rst_o);

  if (HAS_SYNC) begin : g_sync_checks
    // R12: a dropped receive link hides lane 0 in the next cycle
    a_r12_hide_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
      !link_rx_up_i |=> !tx_en_o[0]);
    // R12: a dropped receive link puts the framing core back in reset
    a_r12_reset_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
      !link_rx_up_i |=> jesd_rst_o);
  end

endmodule

// File: tb/txen_seq_test.sv
module txen_seq_test;

  localparam int LANES = 4;
  localparam int DACS  = 3;
  localparam int LUS   = 4;
  localparam int L     = 50 * LUS;
  localparam int REL = 100, INIT = 101, AUTO = 102, TS = 103;

  logic clk = 1'b0;
  logic rst_n, stable, link, rep, ts, done, err;
  logic [LANES-1:0] en, en_ns;
  logic jr, q_init, q_auto, q_ts, q_rs, aerr, rerr;
  logic [1:0] ridx;
  logic jr_ns, ni_ns, na_ns, nt_ns, nr_ns, ae_ns, re_ns;
  logic [1:0] ridx_ns;

  always #10 clk = ~clk;

  txen_seq #(.LANES(LANES), .DACS(DACS), .CLK_HZ(50_000_000), .LOCK_US(LUS),
             .HAS_SYNC(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .clk_stable_i(stable), .link_rx_up_i(link),
    .rep0_up_i(rep), .ts_load_i(ts), .step_done_i(done), .step_err_i(err),
    .tx_en_o(en), .jesd_rst_o(jr), .dac_init_req_o(q_init),
    .sysref_auto_req_o(q_auto), .sysref_ts_req_o(q_ts), .resync_req_o(q_rs),
    .resync_idx_o(ridx), .align_err_o(aerr), .resync_err_o(rerr));

  txen_seq #(.LANES(LANES), .DACS(DACS), .CLK_HZ(50_000_000), .LOCK_US(LUS),
             .HAS_SYNC(1'b0)) uut_nosync (
    .clk(clk), .rst_n(rst_n), .clk_stable_i(stable), .link_rx_up_i(link),
    .rep0_up_i(rep), .ts_load_i(ts), .step_done_i(done), .step_err_i(err),
    .tx_en_o(en_ns), .jesd_rst_o(jr_ns), .dac_init_req_o(ni_ns),
    .sysref_auto_req_o(na_ns), .sysref_ts_req_o(nt_ns), .resync_req_o(nr_ns),
    .resync_idx_o(ridx_ns), .align_err_o(ae_ns), .resync_err_o(re_ns));

  int n_cmp = 0, n_bad = 0;
  int n_init = 0, n_auto = 0, n_ts = 0, n_rs = 0;
  int resp_wait = -1, lat = 0;
  bit resp_err = 0, stray = 0, fail_ts = 0, fail_init = 0;
  int fail_dac = -1;

  // behavioural reference model
  int m_mode, m_cnt, ns_mode, ns_cnt;
  bit m_unhid, m_jon, m_prev, m_pend, m_aerr, m_rerr;
  int m_q[$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  task automatic m_hide();
    m_mode = 2; m_jon = 0; m_unhid = 0; m_pend = 0; m_q.delete();
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_cnt = 0; ns_mode = 0; ns_cnt = 0;
      m_unhid = 0; m_jon = 0; m_prev = 0; m_pend = 0; m_aerr = 0; m_rerr = 0;
      m_q.delete();
    end else begin
      if (ns_mode == 0 && stable) begin ns_mode = 1; ns_cnt = 0; end
      else if (ns_mode == 1) begin
        if (ns_cnt == L - 1) ns_mode = 3; else ns_cnt++;
      end
      case (m_mode)
        0: if (stable) begin m_mode = 1; m_cnt = 0; end
        1: if (m_cnt == L - 1) m_mode = 2; else m_cnt++;
        2: begin m_prev = 0; if (link) m_mode = 3; end
        3: begin
          if (!link) m_hide();
          else if (rep && !m_prev) begin
            m_mode = 4; m_q = '{REL, INIT, AUTO}; m_jon = 1;
          end else if (ts) begin
            m_mode = 4; m_q = '{TS};
            for (int d = 0; d < DACS; d++) m_q.push_back(d);
            m_aerr = 0; m_rerr = 0;
          end
          m_prev = rep;
        end
        4: begin
          if (!link) m_hide();
          else begin
            int h;
            h = m_q[0];
            if (h == REL) void'(m_q.pop_front());
            else if (!m_pend) m_pend = 1;
            else if (done || err) begin
              m_pend = 0;
              if (err && h < REL) begin m_rerr = 1; m_q.delete(); end
              else begin
                if (err && h == TS) m_aerr = 1;
                if (h == AUTO) m_unhid = 1;
                void'(m_q.pop_front());
              end
            end
            if (m_q.size() == 0) m_mode = 3;
          end
          m_prev = rep;
        end
        default: ;
      endcase
    end
  end

  task automatic compare();
    int k;
    logic [3:0] xm;
    k = -1;
    if (m_mode == 4 && link && m_q.size() > 0 && m_q[0] != REL && !m_pend) k = m_q[0];
    xm = (m_mode < 2) ? 4'h0 : (m_unhid ? 4'hF : 4'hE);
    chk("R4 mask", en, xm);
    chk("R5 jesd_rst", jr, !m_jon);
    chk("R6 init_req", q_init, k == INIT);
    chk("R6 auto_req", q_auto, k == AUTO);
    chk("R8 ts_req", q_ts, k == TS);
    chk("R8 resync_req", q_rs, k >= 0 && k < REL);
    if (k >= 0 && k < REL) chk("R8 resync_idx", ridx, k);
    chk("R9 align_err", aerr, m_aerr);
    chk("R10 resync_err", rerr, m_rerr);
    chk("R3 nosync mask", en_ns, (ns_mode == 3) ? 4'hF : 4'h0);
    chk("R3 nosync jesd_rst", jr_ns, 1);
    chk("R3 nosync reqs", {ni_ns, na_ns, nt_ns, nr_ns}, 0);
  endtask

  task automatic tick();
    @(negedge clk);
    if (resp_wait == 0) begin done = 1; err = resp_err; resp_wait = -1; end
    else begin
      done = stray; err = 0;
      if (resp_wait > 0) resp_wait--;
    end
    stray = 0;
    #1;
    compare();
    if (q_init || q_auto || q_ts || q_rs) begin
      resp_wait = lat;
      resp_err = (q_init && fail_init) || (q_ts && fail_ts) ||
                 (q_rs && (int'(ridx) == fail_dac));
    end
    if (q_init) n_init++;
    if (q_auto) n_auto++;
    if (q_ts)   n_ts++;
    if (q_rs)   n_rs++;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic ts_pulse();
    ts = 1; tick(); ts = 0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int s_ts, s_init;
    rst_n = 0; stable = 0; link = 0; rep = 0; ts = 0; done = 0; err = 0;
    run(3);
    chk("R1 reset mask", en, 0);
    chk("R1 reset jesd_rst", jr, 1);
    rst_n = 1;
    run(3);
    chk("R1 idle errs", {aerr, rerr}, 0);
    stable = 1;
    run(100);
    chk("R2 dark mid lock", en, 0);
    chk("R2 nosync dark mid lock", en_ns, 0);
    run(L - 100 + 2);
    chk("R4 hidden after lock", en, 4'hE);
    chk("R3 nosync all on", en_ns, 4'hF);
    link = 1;
    run(5);
    chk("R5 held in reset", jr, 1);
    rep = 1;
    run(12);
    chk("R6 all on after bringup", en, 4'hF);
    chk("R6 step counts", {n_init[7:0], n_auto[7:0]}, 16'h0101);
    stray = 1;
    run(3);
    chk("R11 stray done no request", n_init + n_auto + n_ts + n_rs, 2);
    lat = 3;
    ts_pulse(); run(40);
    chk("R8 sequence counts", {n_ts[7:0], n_rs[7:0]}, 16'h0103);
    fail_ts = 1;
    ts_pulse(); run(40);
    fail_ts = 0;
    chk("R9 align flag", aerr, 1);
    chk("R9 resync continues", n_rs, 6);
    fail_dac = 1;
    ts_pulse(); run(40);
    fail_dac = -1;
    chk("R10 resync flag", rerr, 1);
    chk("R10 align cleared", aerr, 0);
    chk("R10 aborted after idx 1", n_rs, 8);
    ts_pulse(); run(40);
    chk("R10 flags cleared", {aerr, rerr}, 0);
    chk("R10 full resync", n_rs, 11);
    ts_pulse(); run(2);
    link = 0;
    run(1);
    chk("R12 lane0 hidden", en, 4'hE);
    chk("R12 jesd reset", jr, 1);
    s_ts = n_ts;
    run(6);
    ts_pulse(); run(3);
    chk("R13 ts ignored when hidden", n_ts, s_ts);
    lat = 0;
    link = 1;
    run(12);
    chk("R7 bringup rerun", n_init, 2);
    chk("R7 lanes on", en, 4'hF);
    run(20);
    chk("R7 no retrigger", n_init, 2);
    rep = 0;
    run(2);
    s_init = n_auto;
    fail_init = 1;
    rep = 1; ts = 1; tick(); ts = 0;
    run(15);
    fail_init = 0;
    chk("R13 rise wins over ts", n_ts, s_ts);
    chk("R6 init error continues", n_auto, s_init + 1);
    chk("R6 lanes on after error", en, 4'hF);
    finish_run();
  end

endmodule